// File: doc/BRIEF.md
# Addressed Byte-Wide Register Loader

This block lets a slow host fill eight 8-bit data registers over a byte-wide port with two write strobes. One strobe captures the data lines into a holding byte. The other strobe captures them into a command byte. That byte carries a load flag, a 3-bit board number and a 3-bit register index. When the load flag goes from 1 to 0 across two consecutive command writes, and the board number in the second write equals the board's strapped ID, the held byte is copied into the indexed register. Several boards can therefore share one host port, and each one commits only the writes addressed to it.

The eight registers are paired into four 16-bit buses: three input buses and one control bus. Each input bus has its own enable. The two halves of the control bus are enabled separately. A disabled bus, or a disabled half, reads as zero and its drive flag is low. Pad-level tri-stating is left to the instantiating level. The strobes and the data lines are asynchronous to the block's clock. Each strobe passes through a two-flop synchronizer and a rising-edge detector, and the data lines are sampled in the cycle the edge is detected.

Top module: `byte_reg_loader`

## Requirements
- R1: After reset all eight registers, the holding byte and the command byte are 0x00, so every enabled bus reads 0x0000. Because the load flag reads 0 after reset, the first command write cannot commit.
- R2: A rising edge on `wr_hold_stb` captures `host_data` into the holding byte. This byte is what the next commit writes.
- R3: A command byte has this layout: bit 6 is the load flag, bits 5..3 are the board number, and bits 2..0 are the register index. Bit 7 is ignored. A commit happens when the previous command byte had bit 6 set, the new one has bit 6 clear, and the board number in the new one equals `board_strap`. For example, with strap 0, writing 0x46 and then 0x06 loads register 6.
- R4: A command whose board number differs from `board_strap` leaves every register unchanged, even when the load flag falls.
- R5: Two command writes that both have the load flag clear, or both have it set, leave every register unchanged.
- R6: Register index mapping, with low byte in bits 7..0: index 0 and 1 are the low and high bytes of `in3_bus`; 2 and 3 are those of `in2_bus`; 4 and 5 are those of `ctl_bus`; 6 and 7 are those of `in1_bus`.
- R7: A bus whose enable is low reads 0 and its drive flag is low. The register contents are kept and reappear when the enable returns. `oe_ctl_lo` gates `ctl_bus[7:0]` and `ctl_drv[0]`; `oe_ctl_hi` gates `ctl_bus[15:8]` and `ctl_drv[1]`.
- R8: Only a rising edge of a strobe captures data. If a strobe is held high while `host_data` changes, the value present at the edge is kept.
- R9: The strapped board ID can be any value from 0 to 7, and a board responds only to its own number.
- R10: A commit writes the holding byte as it stands when the load flag falls. A holding write made between the two command writes is the one that lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_data | input | 8 | Host byte lines, asynchronous |
| wr_addr_stb | input | 1 | Command-byte write strobe, asynchronous, active on rising edge |
| wr_hold_stb | input | 1 | Holding-byte write strobe, asynchronous, active on rising edge |
| board_strap | input | 3 | Strapped board ID |
| oe_in1 | input | 1 | Enable for input bus 1 |
| oe_in2 | input | 1 | Enable for input bus 2 |
| oe_in3 | input | 1 | Enable for input bus 3 |
| oe_ctl_lo | input | 1 | Enable for control bus bits 7..0 |
| oe_ctl_hi | input | 1 | Enable for control bus bits 15..8 |
| in1_bus | output | 16 | Input bus 1 (registers 7:6) |
| in1_drv | output | 1 | Input bus 1 is driven |
| in2_bus | output | 16 | Input bus 2 (registers 3:2) |
| in2_drv | output | 1 | Input bus 2 is driven |
| in3_bus | output | 16 | Input bus 3 (registers 1:0) |
| in3_drv | output | 1 | Input bus 3 is driven |
| ctl_bus | output | 16 | Control bus (registers 5:4) |
| ctl_drv | output | 2 | Control half drive flags, bit 1 for the high half |

## Verification
The assertions check several rules on every clock. An edge detector never produces two pulses in a row. The holding byte takes the sampled data one cycle after its edge. Every commit follows a 1-to-0 fall of the load flag and carries the strapped board number. No register moves unless a commit is presented, and a commit lands in exactly the indexed register. Other properties are visible only at the ports, so the bench scenarios cover them: the index-to-bus byte map, mismatched board numbers, repeated flag values, strobes held high while the data changes, a holding rewrite between the two command writes, and the enables hiding and restoring register contents.

// File: rtl/brl_pkg.sv
package brl_pkg;

   // Bus slots in register-pair order: pair k holds registers 2k (low) and 2k+1 (high).
   typedef enum logic [1:0] {
      SLOT_IN3 = 2'd0,
      SLOT_IN2 = 2'd1,
      SLOT_CTL = 2'd2,
      SLOT_IN1 = 2'd3
   } bus_slot_e;

   localparam int unsigned SLOT_COUNT = 4;

   // Register index of one byte lane of a bus slot.
   function automatic int unsigned lane_index(input int unsigned slot, input int unsigned hi);
      return 2 * slot + hi;
   endfunction

endpackage

// File: rtl/brl_edge_sync.sv
module brl_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("brl_edge_sync: STAGES must be at least 2");
   end

   // STAGES synchronizer flops plus one history flop for edge detection.
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-1:0], async_i};
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

   // R8: a level held high yields one pulse, never two back to back
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/brl_cmd_capture.sv
module brl_cmd_capture #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned BOARD_W = 3,
   parameter int unsigned REG_AW  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DATA_W-1:0]  data_i,
   input  logic               hold_rise_i,
   input  logic               addr_rise_i,
   input  logic [BOARD_W-1:0] board_id_i,
   output logic               commit_o,
   output logic [REG_AW-1:0]  commit_idx_o,
   output logic [DATA_W-1:0]  commit_data_o
);

   localparam int unsigned FLAG_POS  = REG_AW + BOARD_W;
   localparam int unsigned BOARD_LSB = REG_AW;
   localparam int unsigned BOARD_MSB = REG_AW + BOARD_W - 1;

   if (FLAG_POS >= DATA_W) begin : g_bad_layout
      $error("brl_cmd_capture: command fields do not fit in DATA_W");
   end

   logic [DATA_W-1:0]   hold_q;
   logic [FLAG_POS:0]   cmd_q;
   logic                commit_q;
   logic [REG_AW-1:0]   idx_q;
   logic [DATA_W-1:0]   cdata_q;

   logic                flag_falls;
   logic                board_hit;
   logic                commit_d;

   assign flag_falls = cmd_q[FLAG_POS] & ~data_i[FLAG_POS];
   assign board_hit  = (data_i[BOARD_MSB:BOARD_LSB] == board_id_i);
   assign commit_d   = addr_rise_i & flag_falls & board_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (hold_rise_i) begin
         hold_q <= data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (addr_rise_i) begin
         cmd_q <= data_i[FLAG_POS:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_q <= 1'b0;
         idx_q    <= '0;
         cdata_q  <= '0;
      end else begin
         commit_q <= commit_d;
         if (commit_d) begin
            idx_q   <= data_i[REG_AW-1:0];
            cdata_q <= hold_q;
         end
      end
   end

   assign commit_o      = commit_q;
   assign commit_idx_o  = idx_q;
   assign commit_data_o = cdata_q;

   // R2: holding byte takes the sampled lines one cycle after its edge
   a_r2_hold_capture: assert property (@(posedge clk) disable iff (!rst_n)
      hold_rise_i |=> hold_q == $past(data_i));

   // R3/R5: a commit follows a 1-to-0 fall of the load flag
   a_r3_flag_fell: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> ($past(cmd_q[FLAG_POS]) && !cmd_q[FLAG_POS]));

   // R4: a commit carries the strapped board number
   a_r4_board_match: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> cmd_q[BOARD_MSB:BOARD_LSB] == $past(board_id_i));

endmodule

// File: rtl/brl_reg_bank.sv
module brl_reg_bank #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned N_REGS = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en_i,
   input  logic [IDX_W-1:0]         wr_idx_i,
   input  logic [DATA_W-1:0]        wr_data_i,
   output logic [N_REGS*DATA_W-1:0] regs_o
);

   if (N_REGS > (1 << IDX_W)) begin : g_bad_depth
      $error("brl_reg_bank: N_REGS exceeds index range");
   end

   for (genvar i = 0; i < N_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] byte_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
            byte_q <= wr_data_i;
         end
      end

      assign regs_o[i*DATA_W +: DATA_W] = byte_q;

      // R3: a commit aimed here lands the committed byte
      a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en_i && (wr_idx_i == IDX_W'(i))) |=> byte_q == $past(wr_data_i));
   end

   // R5: no commit, no register change
   a_r5_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(regs_o));

endmodule

// File: rtl/byte_reg_loader.sv
module byte_reg_loader #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BOARD_W     = 3,
   parameter int unsigned REG_AW      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DATA_W-1:0]    host_data,
   input  logic                 wr_addr_stb,
   input  logic                 wr_hold_stb,
   input  logic [BOARD_W-1:0]   board_strap,
   input  logic                 oe_in1,
   input  logic                 oe_in2,
   input  logic                 oe_in3,
   input  logic                 oe_ctl_lo,
   input  logic                 oe_ctl_hi,
   output logic [2*DATA_W-1:0]  in1_bus,
   output logic                 in1_drv,
   output logic [2*DATA_W-1:0]  in2_bus,
   output logic                 in2_drv,
   output logic [2*DATA_W-1:0]  in3_bus,
   output logic                 in3_drv,
   output logic [2*DATA_W-1:0]  ctl_bus,
   output logic [1:0]           ctl_drv
);
   import brl_pkg::*;

   localparam int unsigned N_REGS  = 1 << REG_AW;
   localparam int unsigned BUS_W   = 2 * DATA_W;
   localparam int unsigned N_SLOTS = N_REGS / 2;

   if (N_SLOTS != SLOT_COUNT) begin : g_bad_slots
      $error("byte_reg_loader: register count must form exactly four buses");
   end

   logic                     hold_rise;
   logic                     addr_rise;
   logic                     commit;
   logic [REG_AW-1:0]        commit_idx;
   logic [DATA_W-1:0]        commit_data;
   logic [N_REGS*DATA_W-1:0] regs_flat;
   logic [BUS_W-1:0]         slot_word [N_SLOTS];

   brl_edge_sync #(.STAGES(SYNC_STAGES)) u_hold_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (wr_hold_stb),
      .rise_o  (hold_rise)
   );

   brl_edge_sync #(.STAGES(SYNC_STAGES)) u_addr_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (wr_addr_stb),
      .rise_o  (addr_rise)
   );

   brl_cmd_capture #(
      .DATA_W  (DATA_W),
      .BOARD_W (BOARD_W),
      .REG_AW  (REG_AW)
   ) u_capture (
      .clk           (clk),
      .rst_n         (rst_n),
      .data_i        (host_data),
      .hold_rise_i   (hold_rise),
      .addr_rise_i   (addr_rise),
      .board_id_i    (board_strap),
      .commit_o      (commit),
      .commit_idx_o  (commit_idx),
      .commit_data_o (commit_data)
   );

   brl_reg_bank #(
      .DATA_W (DATA_W),
      .IDX_W  (REG_AW),
      .N_REGS (N_REGS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (commit),
      .wr_idx_i  (commit_idx),
      .wr_data_i (commit_data),
      .regs_o    (regs_flat)
   );

   // Pair registers into 16-bit words, low byte at the even index.
   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      localparam int unsigned LO = lane_index(s, 0);
      localparam int unsigned HI = lane_index(s, 1);
      assign slot_word[s] = {regs_flat[HI*DATA_W +: DATA_W], regs_flat[LO*DATA_W +: DATA_W]};
   end

   assign in3_bus = oe_in3 ? slot_word[SLOT_IN3] : '0;
   assign in2_bus = oe_in2 ? slot_word[SLOT_IN2] : '0;
   assign in1_bus = oe_in1 ? slot_word[SLOT_IN1] : '0;
   assign in3_drv = oe_in3;
   assign in2_drv = oe_in2;
   assign in1_drv = oe_in1;

   assign ctl_bus[DATA_W-1:0]     = oe_ctl_lo ? slot_word[SLOT_CTL][DATA_W-1:0]     : '0;
   assign ctl_bus[BUS_W-1:DATA_W] = oe_ctl_hi ? slot_word[SLOT_CTL][BUS_W-1:DATA_W] : '0;
   assign ctl_drv                 = {oe_ctl_hi, oe_ctl_lo};

   // R7: the control halves are driven only while their own enables are high
   a_r7_ctl_halves: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ctl_drv) == (32'(oe_ctl_hi) + 32'(oe_ctl_lo)));

endmodule

// File: tb/byte_reg_loader_test.sv
module byte_reg_loader_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  host_data = '0;
   logic        wr_addr_stb = 1'b0;
   logic        wr_hold_stb = 1'b0;
   logic [2:0]  board_strap = 3'd2;
   logic        oe_in1 = 1'b1, oe_in2 = 1'b1, oe_in3 = 1'b1, oe_ctl_lo = 1'b1, oe_ctl_hi = 1'b1;
   logic [15:0] in1_bus, in2_bus, in3_bus, ctl_bus;
   logic        in1_drv, in2_drv, in3_drv;
   logic [1:0]  ctl_drv;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [7:0] model [8];

   always #2 clk = ~clk;   // 250 MHz

   byte_reg_loader uut (
      .clk(clk), .rst_n(rst_n), .host_data(host_data),
      .wr_addr_stb(wr_addr_stb), .wr_hold_stb(wr_hold_stb), .board_strap(board_strap),
      .oe_in1(oe_in1), .oe_in2(oe_in2), .oe_in3(oe_in3),
      .oe_ctl_lo(oe_ctl_lo), .oe_ctl_hi(oe_ctl_hi),
      .in1_bus(in1_bus), .in1_drv(in1_drv), .in2_bus(in2_bus), .in2_drv(in2_drv),
      .in3_bus(in3_bus), .in3_drv(in3_drv), .ctl_bus(ctl_bus), .ctl_drv(ctl_drv)
   );

   // {board, index, byte}; expected commit decided by board == strap (R4, R6)
   localparam logic [13:0] VEC [10] = '{
      {3'd2, 3'd6, 8'hA5}, {3'd2, 3'd7, 8'h3C}, {3'd2, 3'd0, 8'h11},
      {3'd5, 3'd1, 8'hEE}, {3'd2, 3'd1, 8'h22}, {3'd2, 3'd2, 8'h5A},
      {3'd2, 3'd3, 8'hC3}, {3'd0, 3'd4, 8'h99}, {3'd2, 3'd4, 8'h0F},
      {3'd2, 3'd5, 8'hF0}
   };

   function automatic logic [15:0] exp_word(input int slot);
      return {model[2*slot+1], model[2*slot]};
   endfunction

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "in3_bus", in3_bus, exp_word(0));
      chk(req, "in2_bus", in2_bus, exp_word(1));
      chk(req, "ctl_bus", ctl_bus, exp_word(2));
      chk(req, "in1_bus", in1_bus, exp_word(3));
   endtask

   task automatic strobe(input bit is_cmd, input logic [7:0] val);
      @(negedge clk) host_data = val;
      repeat (2) @(negedge clk);
      if (is_cmd) wr_addr_stb = 1'b1; else wr_hold_stb = 1'b1;
      repeat (4) @(negedge clk);
      if (is_cmd) wr_addr_stb = 1'b0; else wr_hold_stb = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic load(input logic [2:0] board, input logic [2:0] idx, input logic [7:0] val);
      strobe(1'b0, val);
      strobe(1'b1, {2'b01, board, idx});
      strobe(1'b1, {2'b00, board, idx});
   endtask

   task automatic clear_model();
      for (int i = 0; i < 8; i++) model[i] = 8'h00;
   endtask

   initial begin
      clear_model();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk_all("R1");
      chk("R1", "drive flags", {11'b0, in1_drv, in2_drv, in3_drv, ctl_drv}, 16'h001F);
      // R1: a lone LD=0 command after reset does not commit
      strobe(1'b0, 8'h6B);
      strobe(1'b1, {2'b00, 3'd2, 3'd0});
      chk_all("R1");

      // R6 / R4: vector table walk, strap = 2
      for (int v = 0; v < 10; v++) begin
         logic [2:0] bd;
         logic [2:0] ix;
         logic [7:0] dv;
         {bd, ix, dv} = VEC[v];
         load(bd, ix, dv);
         if (bd == board_strap) model[ix] = dv;
         chk_all(bd == board_strap ? "R6" : "R4");
      end

      // R5: flag low twice -> no commit
      strobe(1'b0, 8'hDD);
      strobe(1'b1, {2'b00, 3'd2, 3'd0});
      strobe(1'b1, {2'b00, 3'd2, 3'd0});
      chk_all("R5");
      // R5: flag high twice -> no commit
      strobe(1'b1, {2'b01, 3'd2, 3'd0});
      strobe(1'b1, {2'b01, 3'd2, 3'd0});
      chk_all("R5");
      // R3: the following fall commits the held byte
      strobe(1'b1, {2'b00, 3'd2, 3'd0});
      model[0] = 8'hDD;
      chk_all("R3");

      // R8: hold strobe kept high while data changes
      @(negedge clk) host_data = 8'h77;
      repeat (2) @(negedge clk);
      wr_hold_stb = 1'b1;
      repeat (4) @(negedge clk);
      host_data = 8'h88;
      repeat (4) @(negedge clk);
      wr_hold_stb = 1'b0;
      repeat (4) @(negedge clk);
      strobe(1'b1, {2'b01, 3'd2, 3'd2});
      strobe(1'b1, {2'b00, 3'd2, 3'd2});
      model[2] = 8'h77;
      chk_all("R8");

      // R10 / R2: holding rewritten between command writes
      strobe(1'b0, 8'h41);
      strobe(1'b1, {2'b01, 3'd2, 3'd3});
      strobe(1'b0, 8'h42);
      strobe(1'b1, {2'b00, 3'd2, 3'd3});
      model[3] = 8'h42;
      chk_all("R10");

      // R7: enables hide and restore contents, control halves independent
      oe_in1 = 1'b0; oe_ctl_lo = 1'b0;
      @(negedge clk);
      chk("R7", "in1 disabled", in1_bus, 16'h0000);
      chk("R7", "in1_drv", {15'b0, in1_drv}, 16'h0000);
      chk("R7", "ctl low half off", ctl_bus, {model[5], 8'h00});
      chk("R7", "ctl_drv", {14'b0, ctl_drv}, 16'h0002);
      oe_ctl_lo = 1'b1; oe_ctl_hi = 1'b0;
      @(negedge clk);
      chk("R7", "ctl high half off", ctl_bus, {8'h00, model[4]});
      oe_in1 = 1'b1; oe_ctl_hi = 1'b1;
      @(negedge clk);
      chk_all("R7");

      // R9 / R3: other strap values, including the documented 0x46 then 0x06 sequence
      board_strap = 3'd0;
      strobe(1'b0, 8'hB7);
      strobe(1'b1, 8'h46);
      strobe(1'b1, 8'h06);
      model[6] = 8'hB7;
      chk_all("R3");
      board_strap = 3'd7;
      load(3'd2, 3'd7, 8'h13);
      chk_all("R9");
      load(3'd7, 3'd7, 8'h13);
      model[7] = 8'h13;
      chk_all("R9");

      // R1: reset mid-run clears everything
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      clear_model();
      chk_all("R1");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule